// File: doc/BRIEF.md
# Early Carry-Select Adder

This block is a purely combinational binary adder. It takes two operand words and a carry-in bit, and it returns a sum word of the same width and a carry-out bit. The operand width is a parameter, and the default is 128 bits.

Inside each adder group, the per-bit propagate and generate words are computed once. Two carry chains then run from these shared words. One chain assumes an incoming carry of zero, and the other assumes an incoming carry of one. The real carry-in picks between the two carry words before any sum bit is formed. Each sum bit is then the propagate bit XORed with the selected carry from the bit below it. So only one sum word is ever built, and none is discarded.

A staging parameter can split the operand into groups of growing width. The carry-out of each group feeds the carry-in of the next group. The result is the same as in the single-group form. Only the internal structure differs.

Top module: `esa_top`

## Requirements
- R1: For every input combination, {carry_out, sum_out} equals op_a + op_b + carry_in, computed at WIDTH+1 bits.
- R2: Each group forms a propagate word as the bitwise XOR of its operand slices and a generate word as the bitwise AND of them. Adding two equal single-bit operands at bit k with carry_in 0 yields only bit k+1 set.
- R3: The zero-assumed chain computes carry(i) = gen(i) | (prop(i) & carry(i-1)) with an incoming carry of 0. The one-assumed chain uses the same recurrence with an incoming carry of 1. With alternating 1010… and 0101… operands, carry_in 1 ripples a carry across the full width (sum 0, carry_out 1), while carry_in 0 gives all ones and carry_out 0.
- R4: A 1 in the zero-assumed carry word always comes with a 1 at the same position of the one-assumed word. The selection is an AND-OR per bit: sel(i) = c0(i) | (carry_in & c1(i)). For fixed operands, results with carry_in 1 and carry_in 0 differ by exactly one.
- R5: With carry_in 0 the result equals op_a + op_b. With carry_in 1 it equals op_a + op_b + 1.
- R6: carry_out is the top bit of the last group's selected carry word. All-ones plus all-ones with carry_in 1 gives an all-ones sum and carry_out 1. All-ones plus zero with carry_in 1 gives a zero sum and carry_out 1.
- R7: Sum bit 0 is prop(0) XOR carry_in. Zero plus zero with carry_in 1 gives sum 1 and carry_out 0.
- R8: With STAGED = 1, the operand splits into consecutive groups. Their widths start at FIRST_W and grow by one, the last group is clipped so that the widths total WIDTH, and each group's carry-out drives the next group's carry-in. Outputs are identical to the single-group build for every input.
- R9: The default WIDTH is 128, and both outputs are 0 when all inputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry |
| sum_out | output | WIDTH | Sum word |
| carry_out | output | 1 | Outgoing carry |

## Verification
On every input change, the assertions check three things. The zero-assumed carry word never holds a 1 where the one-assumed word holds a 0. The selected carry word matches the chain named by the carry-in. Each group and the full adder agree with a wide arithmetic sum.

Some behaviour only the bench scenarios can show. These cases are the full-width ripple patterns, the all-ones and zero-plus-carry corners, and the one-step difference between the two carry-in values. Another is the agreement between the staged and the single-group builds, since that needs two instances driven alike.

// File: rtl/esa_pkg.sv
// Shared helpers for the early carry-select adder.
// Computes the group layout: one group when unstaged, otherwise groups
// growing by one bit from a first width, with the last group clipped.
package esa_pkg;

    // Width of group g (0 when g is past the last group).
    function automatic int grp_w(input int total, input int first, input bit staged, input int g);
        int rem;
        int w;
        int res;
        res = 0;
        if (!staged) begin
            res = (g == 0) ? total : 0;
        end else begin
            rem = total;
            w   = first;
            for (int k = 0; k <= g; k++) begin
                res = (w < rem) ? w : rem;
                rem = rem - res;
                w   = w + 1;
            end
        end
        return res;
    endfunction

    // Number of groups needed to cover the full width.
    function automatic int grp_count(input int total, input int first, input bit staged);
        int rem;
        int w;
        int cnt;
        if (!staged) return 1;
        rem = total;
        w   = first;
        cnt = 0;
        while (rem > 0) begin
            rem = rem - ((w < rem) ? w : rem);
            w   = w + 1;
            cnt = cnt + 1;
        end
        return cnt;
    endfunction

    // Lowest bit index of group g.
    function automatic int grp_lo(input int total, input int first, input bit staged, input int g);
        int lo;
        lo = 0;
        for (int k = 0; k < g; k++) lo = lo + grp_w(total, first, staged, k);
        return lo;
    endfunction

endpackage

// File: rtl/esa_half.sv
// Per-bit propagate/generate former.
// Assumes nothing about operand values; W >= 1.
module esa_half #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);
    // Form the shared half-sum and half-carry words (R2).
    always_comb begin
        prop = a ^ b;
        gen  = a & b;
    end
endmodule

// File: rtl/esa_chain.sv
// Carry chain with a fixed incoming carry.
// The lowest bit folds the constant incoming carry; the rest ripple.
module esa_chain #(
    parameter int W        = 8,
    parameter bit CIN_ONE  = 1'b0
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    output logic [W-1:0] cw
);
    // Lowest bit with the constant incoming carry folded in (R3).
    generate
        if (CIN_ONE) begin : g_low_one
            assign cw[0] = gen[0] | prop[0];
        end else begin : g_low_zero
            assign cw[0] = gen[0];
        end
    endgenerate

    // Ripple the recurrence through the upper bits (R3).
    generate
        for (genvar i = 1; i < W; i++) begin : g_bit
            assign cw[i] = gen[i] | (prop[i] & cw[i-1]);
        end
    endgenerate
endmodule

// File: rtl/esa_group.sv
// One early carry-select group: shared half words, two anticipated
// carry chains, AND-OR selection by the group carry-in, then the sum.
// Assumes W >= 1.
module esa_group #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] c0w;
    logic [W-1:0] c1w;
    logic [W-1:0] csel;

    esa_half #(.W(W)) u_half (
        .a    (a),
        .b    (b),
        .prop (prop),
        .gen  (gen)
    );

    esa_chain #(.W(W), .CIN_ONE(1'b0)) u_chain0 (
        .prop (prop),
        .gen  (gen),
        .cw   (c0w)
    );

    esa_chain #(.W(W), .CIN_ONE(1'b1)) u_chain1 (
        .prop (prop),
        .gen  (gen),
        .cw   (c1w)
    );

    // AND-OR selection relying on carry-word dominance (R4).
    always_comb begin
        csel = c0w | ({W{cin}} & c1w);
    end

    // Group carry-out is the top selected carry (R6).
    assign cout = csel[W-1];

    // Sum bit 0 uses the carry-in directly (R7).
    assign sum[0] = prop[0] ^ cin;

    // Upper sum bits use the selected carry from below.
    generate
        if (W > 1) begin : g_upper
            assign sum[W-1:1] = prop[W-1:1] ^ csel[W-2:0];
        end
    endgenerate

    // Check dominance, selection and group arithmetic.
    always_comb begin
        logic [W:0] ref_v;
        ref_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        if (!$isunknown({a, b, cin})) begin
            p_dominate_r4: assert ((c0w & ~c1w) == '0)
                else $error("carry-0 word has a 1 where carry-1 word has 0");
            p_select_r4: assert (csel == (cin ? c1w : c0w))
                else $error("selected carry word does not match chain");
            p_group_sum_r1: assert ({cout, sum} == ref_v)
                else $error("group result differs from arithmetic sum");
        end
    end
endmodule

// File: rtl/esa_top.sv
// Early carry-select adder top. One group, or a staged cascade of groups
// of growing width whose carry-outs feed the next group's carry-in.
// Purely combinational; FIRST_W >= 1 when staged.
module esa_top #(
    parameter int WIDTH   = 128,
    parameter bit STAGED  = 1'b0,
    parameter int FIRST_W = 2
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NG = esa_pkg::grp_count(WIDTH, FIRST_W, STAGED);

    logic [NG:0] link;

    assign link[0] = carry_in;

    // Instantiate the groups and chain their carries (R8).
    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            localparam int LO = esa_pkg::grp_lo(WIDTH, FIRST_W, STAGED, g);
            localparam int GW = esa_pkg::grp_w(WIDTH, FIRST_W, STAGED, g);
            esa_group #(.W(GW)) u_grp (
                .a    (op_a[LO +: GW]),
                .b    (op_b[LO +: GW]),
                .cin  (link[g]),
                .sum  (sum_out[LO +: GW]),
                .cout (link[g+1])
            );
        end
    endgenerate

    // Carry-out from the last group (R6).
    assign carry_out = link[NG];

    // Whole-adder arithmetic check (R1, R5).
    always_comb begin
        logic [WIDTH:0] ref_v;
        ref_v = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in})) begin
            p_total_sum_r1: assert ({carry_out, sum_out} == ref_v)
                else $error("adder result differs from arithmetic sum");
            p_lsb_r7: assert (sum_out[0] == (op_a[0] ^ op_b[0] ^ carry_in))
                else $error("sum bit 0 wrong");
        end
    end
endmodule

// File: tb/sim_esa_top.sv
// Self-checking bench for the early carry-select adder.
module sim_esa_top;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W-1:0] s0;
    logic         co0;
    logic [W-1:0] s1;
    logic         co1;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    esa_top #(.WIDTH(W), .STAGED(1'b0)) u0 (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s0), .carry_out(co0)
    );

    esa_top #(.WIDTH(W), .STAGED(1'b1), .FIRST_W(2)) u1 (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s1), .carry_out(co1)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        for (int k = 0; k < W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, sample 2 ns after the next rising edge.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        a  = x;
        b  = y;
        ci = c;
        @(posedge clk);
        #2;
    endtask

    initial begin
        logic [W:0] r_hi;
        logic [W:0] r_lo;
        logic [W-1:0] ones;
        logic [W-1:0] alt;
        void'($urandom(32'h1a2b3c4d));
        ones = '1;
        alt  = '0;
        for (int k = 0; k < W; k += 2) alt[k+1] = 1'b1;
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R9: zero inputs give zero outputs at default width.
        apply('0, '0, 1'b0);
        check("R9 zero", {co0, s0}, '0);
        check("R9 width", (W+1)'($bits(s0)), (W+1)'(128));

        // R7: zero plus zero with carry-in.
        apply('0, '0, 1'b1);
        check("R7 lsb", {co0, s0}, (W+1)'(1));

        // R6: all-ones corners.
        apply(ones, ones, 1'b1);
        check("R6 ones+ones+1", {co0, s0}, {1'b1, ones});
        apply(ones, '0, 1'b1);
        check("R6 ones+0+1", {co0, s0}, {1'b1, {W{1'b0}}});
        check("R8 staged ones+0+1", {co1, s1}, {1'b1, {W{1'b0}}});

        // R3: alternating patterns, full-width ripple.
        apply(alt, ~alt, 1'b0);
        check("R3 alt cin0", {co0, s0}, {1'b0, ones});
        apply(alt, ~alt, 1'b1);
        check("R3 alt cin1", {co0, s0}, {1'b1, {W{1'b0}}});
        check("R8 staged alt cin1", {co1, s1}, {1'b1, {W{1'b0}}});

        // R2: equal single bits move up one place.
        for (int k = 0; k < W; k += 37) begin
            apply(W'(1) << k, W'(1) << k, 1'b0);
            check("R2 bit pair", {co0, s0}, (W+1)'(1) << (k + 1));
        end

        // R5: small known values for each carry-in.
        apply(W'(5), W'(3), 1'b0);
        check("R5 cin0", {co0, s0}, (W+1)'(8));
        apply(W'(5), W'(3), 1'b1);
        check("R5 cin1", {co0, s0}, (W+1)'(9));

        // R4, R1, R8: random operands with both carry-in values.
        for (int it = 0; it < 300; it++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = rnd_word();
            y = rnd_word();
            if (it % 10 == 0) y = ~x;
            apply(x, y, 1'b0);
            r_lo = {co0, s0};
            check("R1 random cin0", r_lo, ref_add(x, y, 1'b0));
            check("R8 staged cin0", {co1, s1}, r_lo);
            apply(x, y, 1'b1);
            r_hi = {co0, s0};
            check("R1 random cin1", r_hi, ref_add(x, y, 1'b1));
            check("R8 staged cin1", {co1, s1}, r_hi);
            check("R4 step", r_hi - r_lo, (W+1)'(1));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule